// File: doc/BRIEF.md
# Deferred Invalidation Queue with Read-Barrier Stall

This block sits between the coherence interconnect and the tag array of one cache. Incoming invalidations for a line are acknowledged in the same cycle they are presented, and are then held in a small FIFO. They are applied to the cache tags later, one at a time, whenever the tag port can take one. Until an entry is applied, the cache keeps the line and the stale data stays readable.

A read-barrier strobe tags every entry that is in the queue at that moment. A load whose line matches a tagged, still-pending entry is held by a stall signal until that entry has been written to the tags. Once the line is Invalid, the load misses and refetches. Loads that match only untagged entries, or no entry at all, run without stalling.

Top module: `inv_queue`

## Requirements
- R1: After reset the queue is empty. `cache_inv_valid_o` and `ld_stall_o` are low.
- R2: While fewer than DEPTH entries are held, `inv_ack_o` equals `inv_valid_i` in the same cycle. The line is enqueued at the clock edge where both are high.
- R3: Accepting an invalidation does not touch the cache at once. An accepted line reaches `cache_inv_valid_o` at the earliest in the following cycle. Until it is applied, a load to that line with no barrier since its arrival does not stall.
- R4: Entries are presented to the cache port in arrival order. The head is retired at each edge where `cache_inv_valid_o` and `cache_inv_ready_i` are both high, so at most one entry retires per cycle. While `cache_inv_ready_i` is low, the head line is held unchanged.
- R5: A high `rbar_i` at a clock edge tags every entry held before that edge. An entry accepted at the same edge or later is not tagged.
- R6: `ld_stall_o` is high in any cycle where `ld_valid_i` is high and a tagged pending entry has a line equal to `ld_line_i`. It follows the load inputs combinationally.
- R7: A stall is released in the cycle after the last tagged entry for that line retires.
- R8: A load whose line matches only untagged entries, or no entry, is not stalled. `ld_stall_o` is never high without `ld_valid_i`.
- R9: With DEPTH entries held, `inv_ack_o` stays low even if an entry retires in that cycle. Acknowledgement resumes in the cycle after a retirement frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inv_valid_i | input | 1 | Invalidation request present |
| inv_line_i | input | LINE_W | Line address to invalidate |
| inv_ack_o | output | 1 | Request accepted and acknowledged this cycle |
| cache_inv_valid_o | output | 1 | Head entry offered to the tag array |
| cache_inv_line_o | output | LINE_W | Line address of the head entry |
| cache_inv_ready_i | input | 1 | Tag array applies the offered invalidation this cycle |
| rbar_i | input | 1 | Read-barrier strobe |
| ld_valid_i | input | 1 | Load lookup present |
| ld_line_i | input | LINE_W | Line address of the load |
| ld_stall_o | output | 1 | Load must wait for a tagged pending invalidation |

## Verification
The bench builds the block with its defaults: a depth of 4 and 8-bit line addresses. The shallow queue makes the full condition and the withheld acknowledgement come up often under random traffic. Random load addresses are drawn from only four values, so loads often hit a queued line. Under these settings duplicate entries for one line, with mixed tags, are common, as are barriers that coincide with a push or a pop. Directed sequences cover the cycle a stall is released and the cycle acknowledgement returns after the queue was full.

// File: rtl/inv_q_pkg.sv
package inv_q_pkg;
  typedef struct packed {
    logic vld;
    logic mk;
  } slot_flags_t;

  function automatic int unsigned ptr_bits(int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/inv_q_ctrl.sv
module inv_q_ctrl #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PTR_W = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= nxt(tail_q);
      if (pop_i)  head_q <= nxt(head_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CNT_W'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/inv_q_slots.sv
module inv_q_slots
  import inv_q_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LINE_W = 8,
  parameter int unsigned PTR_W  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [PTR_W-1:0]             tail_i,
  input  logic [LINE_W-1:0]            line_i,
  input  logic                         pop_i,
  input  logic [PTR_W-1:0]             head_i,
  input  logic                         rbar_i,
  output slot_flags_t [DEPTH-1:0]      flags_o,
  output logic [DEPTH-1:0][LINE_W-1:0] lines_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    slot_flags_t      fl_q;
    logic [LINE_W-1:0] ln_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fl_q <= '0;
        ln_q <= '0;
      end else if (pop_i && head_i == PTR_W'(i)) begin
        fl_q <= '0;
      end else if (push_i && tail_i == PTR_W'(i)) begin
        fl_q <= '{vld: 1'b1, mk: 1'b0};  // new arrivals never carry an older barrier
        ln_q <= line_i;
      end else if (rbar_i && fl_q.vld) begin
        fl_q.mk <= 1'b1;
      end
    end

    assign flags_o[i] = fl_q;
    assign lines_o[i] = ln_q;
  end
endmodule

// File: rtl/inv_q_match.sv
module inv_q_match
  import inv_q_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LINE_W = 8
) (
  input  slot_flags_t [DEPTH-1:0]      flags_i,
  input  logic [DEPTH-1:0][LINE_W-1:0] lines_i,
  input  logic                         ld_valid_i,
  input  logic [LINE_W-1:0]            ld_line_i,
  output logic                         stall_o
);
  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = flags_i[i].vld && flags_i[i].mk && (lines_i[i] == ld_line_i);
  end

  assign stall_o = ld_valid_i && (|hit);
endmodule

// File: rtl/inv_queue.sv
module inv_queue
  import inv_q_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LINE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_valid_i,
  input  logic [LINE_W-1:0] inv_line_i,
  output logic              inv_ack_o,
  output logic              cache_inv_valid_o,
  output logic [LINE_W-1:0] cache_inv_line_o,
  input  logic              cache_inv_ready_i,
  input  logic              rbar_i,
  input  logic              ld_valid_i,
  input  logic [LINE_W-1:0] ld_line_i,
  output logic              ld_stall_o
);
  localparam int unsigned PTR_W = ptr_bits(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] cnt_q;
  logic full, push, pop;
  slot_flags_t [DEPTH-1:0]      flags;
  logic [DEPTH-1:0][LINE_W-1:0] lines;

  // full check uses held count only: no path from cache ready to ack
  assign push = inv_valid_i && !full;
  assign pop  = cache_inv_valid_o && cache_inv_ready_i;
  assign inv_ack_o = push;

  inv_q_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop),
    .head_o(head), .tail_o(tail), .cnt_o(cnt_q), .full_o(full)
  );

  inv_q_slots #(.DEPTH(DEPTH), .LINE_W(LINE_W), .PTR_W(PTR_W)) u_slots (
    .clk_i, .rst_ni, .push_i(push), .tail_i(tail), .line_i(inv_line_i),
    .pop_i(pop), .head_i(head), .rbar_i, .flags_o(flags), .lines_o(lines)
  );

  inv_q_match #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_match (
    .flags_i(flags), .lines_i(lines), .ld_valid_i, .ld_line_i, .stall_o(ld_stall_o)
  );

  assign cache_inv_valid_o = flags[head].vld;
  assign cache_inv_line_o  = lines[head];
endmodule

// File: rtl/inv_queue_chk.sv
module inv_queue_chk #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LINE_W = 8,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inv_valid_i,
  input logic              inv_ack_o,
  input logic              cache_inv_valid_o,
  input logic              cache_inv_ready_i,
  input logic [LINE_W-1:0] cache_inv_line_o,
  input logic              ld_valid_i,
  input logic              ld_stall_o,
  input logic [CNT_W-1:0]  cnt_i
);
  // R2
  ack_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_ack_o |-> inv_valid_i);

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_W'(DEPTH)) |-> !inv_ack_o);

  // R4
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_inv_valid_o && !cache_inv_ready_i) |=> (cache_inv_valid_o && $stable(cache_inv_line_o)));

  // R4
  one_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_inv_valid_o && cache_inv_ready_i && !inv_ack_o) |=> (cnt_i == $past(cnt_i) - CNT_W'(1)));

  // R2
  grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_ack_o && !(cache_inv_valid_o && cache_inv_ready_i)) |=> (cnt_i == $past(cnt_i) + CNT_W'(1)));

  // R8
  stall_needs_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_stall_o |-> ld_valid_i);

  // R1
  empty_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> (!cache_inv_valid_o && !ld_stall_o));
endmodule

bind inv_queue inv_queue_chk #(.DEPTH(DEPTH), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .inv_valid_i(inv_valid_i), .inv_ack_o(inv_ack_o),
  .cache_inv_valid_o(cache_inv_valid_o), .cache_inv_ready_i(cache_inv_ready_i),
  .cache_inv_line_o(cache_inv_line_o), .ld_valid_i(ld_valid_i),
  .ld_stall_o(ld_stall_o), .cnt_i(cnt_q)
);

// File: tb/sim_inv_queue.sv
`timescale 1ns/1ps
module sim_inv_queue;
  localparam int DEPTH  = 4;
  localparam int LINE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iv = 1'b0, rdy = 1'b0, rb = 1'b0, lv = 1'b0;
  logic [LINE_W-1:0] il = '0, ll = '0;
  logic ack, cv, stall;
  logic [LINE_W-1:0] cl;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [LINE_W-1:0] q_line [DEPTH];
  bit                q_mark [DEPTH];
  int                q_cnt = 0;

  always #2 clk = ~clk;

  inv_queue #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .inv_valid_i(iv), .inv_line_i(il), .inv_ack_o(ack),
    .cache_inv_valid_o(cv), .cache_inv_line_o(cl), .cache_inv_ready_i(rdy),
    .rbar_i(rb), .ld_valid_i(lv), .ld_line_i(ll), .ld_stall_o(stall)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  function automatic bit exp_stall(bit v, logic [LINE_W-1:0] a);
    bit s = 0;
    for (int k = 0; k < DEPTH; k++)
      if (k < q_cnt && q_mark[k] && q_line[k] == a) s = 1;
    return v && s;
  endfunction

  function automatic void model_edge(bit pushed, bit popped, bit bar, logic [LINE_W-1:0] a);
    if (popped) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        q_line[k] = q_line[k+1];
        q_mark[k] = q_mark[k+1];
      end
      q_cnt--;
    end
    if (bar) for (int k = 0; k < DEPTH; k++) if (k < q_cnt) q_mark[k] = 1;
    if (pushed) begin
      q_line[q_cnt] = a;
      q_mark[q_cnt] = 0;
      q_cnt++;
    end
  endfunction

  task automatic step(bit i_v, logic [LINE_W-1:0] i_l, bit b, bit r, bit l_v,
                      logic [LINE_W-1:0] l_l, string tg);
    bit e_ack, e_cv, e_st;
    string ta, tc, ts;
    @(negedge clk);
    iv = i_v; il = i_l; rb = b; rdy = r; lv = l_v; ll = l_l;
    #1;
    e_ack = i_v && (q_cnt < DEPTH);
    e_cv  = (q_cnt > 0);
    e_st  = exp_stall(l_v, l_l);
    ta = (tg != "") ? tg : ((q_cnt == DEPTH) ? "R9" : "R2");
    tc = (tg != "") ? tg : "R4";
    ts = (tg != "") ? tg : (e_st ? "R6" : "R8");
    chk(ta, 32'(ack), 32'(e_ack));
    chk(tc, 32'(cv), 32'(e_cv));
    if (e_cv) chk(tc, 32'(cl), 32'(q_line[0]));
    chk(ts, 32'(stall), 32'(e_st));
    @(posedge clk);
    model_edge(e_ack, e_cv && r, b, i_l);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #9;
    // R1 reset state
    chk("R1", 32'(cv), 0);
    chk("R1", 32'(stall), 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1", 32'(cv), 0);
    chk("R1", 32'(ack), 0);

    // R3: accepted now, not at cache port yet, old line still readable
    step(1, 8'd5, 0, 0, 1, 8'd5, "R3");
    step(0, 8'd0, 0, 0, 1, 8'd5, "R3");
    // R5: barrier with simultaneous push tags only older entry
    step(1, 8'd9, 1, 0, 0, 8'd0, "R5");
    step(0, 8'd0, 0, 0, 1, 8'd9, "R5");
    step(0, 8'd0, 0, 0, 1, 8'd5, "R6");
    // fill, then R9 withheld ack even while retiring
    step(1, 8'd1, 0, 0, 0, 8'd0, "R2");
    step(1, 8'd2, 0, 0, 0, 8'd0, "R2");
    step(1, 8'd3, 0, 0, 0, 8'd0, "R9");
    step(1, 8'd3, 0, 1, 1, 8'd5, "R9");
    step(1, 8'd3, 0, 0, 0, 8'd0, "R9");
    // R7: tag all, retire line 9, stall drops next cycle
    step(0, 8'd0, 1, 0, 0, 8'd0, "R5");
    step(0, 8'd0, 0, 1, 1, 8'd9, "R7");
    step(0, 8'd0, 0, 0, 1, 8'd9, "R7");
    for (int k = 0; k < 4; k++) step(0, 8'd0, 0, 1, 0, 8'd0, "R4");

    for (int c = 0; c < 4000; c++)
      step(($urandom % 10) < 6, LINE_W'($urandom % 4), ($urandom % 100) < 15,
           ($urandom % 2) == 1, ($urandom % 10) < 7, LINE_W'($urandom % 4), "");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule